// File: doc/BRIEF.md
# Control Endpoint IN Transfer-Size Tracker

This block follows one IN transfer on the control endpoint of a USB device. While the endpoint is idle, software writes a single 32-bit size register that holds a byte count and a packet count, then raises the enable. While the endpoint is enabled, the hardware owns both counts. The byte count falls each time the memory side writes a packet into the transmit FIFO. The packet count falls each time the bus side drains a packet from that FIFO.

When both counts reach zero the block ends the transfer. It drops the enable and sets a sticky transfer-complete flag in the same clock edge. Two other sticky flags record a disable requested by software and a bus fault seen in DMA mode. Software clears each flag by writing 1 to it. If the byte count is set equal to the maximum packet size, the block signals completion after every packet.

Top module: `ep0_in_xfer_tracker`

## Requirements
- R1: After reset the size register reads 0x00000000, `ep_en` is low and all three interrupt flags are low.
- R2: Read while idle, the register shows the packet count in bits 20:19 and the byte count in bits 6:0. Every other bit reads zero, so writing all ones reads back 0x0018007F.
- R3: A register write is accepted only while the endpoint is idle, and a write in the same cycle as `ep_en_set` is loaded before the transfer starts. While the endpoint is enabled, writes and further `ep_en_set` pulses are ignored.
- R4: While the endpoint is enabled the register reads as all zeros.
- R5: Each `mem_pkt_wr` while enabled lowers the byte count by `max_pkt`. If `mem_pkt_last` is also high, the count falls by `mem_pkt_len` instead. The count saturates at zero.
- R6: Each `fifo_pkt_rd` while enabled lowers the packet count by one, saturating at zero.
- R7: When both counts would be zero after the current edge while enabled, that same edge clears `ep_en` and sets `irq_flags[0]` (transfer complete).
- R8: `ep_dis_req` while enabled clears `ep_en` and sets `irq_flags[1]` (disabled). If completion occurs in the same cycle, only `irq_flags[0]` is set.
- R9: `irq_flags[2]` (bus fault) is set only when `bus_err` and `dma_mode` are both high while enabled.
- R10: The flags are sticky and are cleared by writing 1 to the matching bit of `irq_clr`. A set and a clear of the same bit in one cycle leave that bit set.
- R11: `mem_pkt_wr` and `fifo_pkt_rd` have no effect on either count while the endpoint is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sz_wr | input | 1 | Size register write strobe |
| sz_wdata | input | 32 | Size register write data |
| sz_rdata | output | 32 | Size register read value |
| ep_en_set | input | 1 | Software sets the endpoint enable |
| ep_dis_req | input | 1 | Software requests endpoint disable |
| ep_en | output | 1 | Endpoint enabled |
| max_pkt | input | 7 | Maximum packet size in bytes |
| mem_pkt_wr | input | 1 | A packet was written from memory into the FIFO |
| mem_pkt_last | input | 1 | That packet is short; its length is on `mem_pkt_len` |
| mem_pkt_len | input | 7 | Byte length of a short packet |
| fifo_pkt_rd | input | 1 | A packet was read out of the FIFO toward the bus |
| dma_mode | input | 1 | Internal DMA mode active |
| bus_err | input | 1 | Bus read or write failure |
| irq_clr | input | 3 | Write-1-to-clear for the flags |
| irq_flags | output | 3 | Bit0 complete, bit1 disabled, bit2 bus fault |

## Verification
The properties assume that every input is a known level, sampled once per rising edge. Each strobe counts as one event for the cycle it is high. Nothing is assumed about ordering between the memory-side and bus-side strobes or about the relation of `mem_pkt_len` to `max_pkt`, because the counters saturate. The random stimulus drives every strobe as a single-cycle pulse with a bounded probability and keeps the levels binary after reset. This lets transfers start, run, finish and be aborted in many interleavings without leaving that envelope.

// File: rtl/ep0_xfer_pkg.sv
package ep0_xfer_pkg;
  localparam int REG_W    = 32;
  localparam int BYTE_W   = 7;
  localparam int PKT_W    = 2;
  localparam int BYTE_LSB = 0;
  localparam int PKT_LSB  = 19;
  localparam int NUM_IRQ  = 3;

  // flag vector: bit0 complete, bit1 disabled, bit2 bus fault
  typedef struct packed {
    logic buserr;
    logic dis;
    logic done;
  } irq_vec_t;
endpackage

// File: rtl/ep0_down_ctr.sv
module ep0_down_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  input  logic [W-1:0] dec_amt,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  logic upd;

  always_comb begin
    upd     = load | dec_en;
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = load_val;
    end else if (dec_en) begin
      cnt_nxt = (cnt_q > dec_amt) ? (cnt_q - dec_amt) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ep0_sticky_flag.sv
module ep0_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nxt;
  logic upd;

  always_comb begin
    upd   = set | clr;
    q_nxt = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (upd) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/ep0_in_xfer_tracker.sv
module ep0_in_xfer_tracker
  import ep0_xfer_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int BW  = BYTE_W,
  parameter int PW  = PKT_W,
  parameter int BLO = BYTE_LSB,
  parameter int PLO = PKT_LSB,
  parameter int NI  = NUM_IRQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sz_wr,
  input  logic [RW-1:0] sz_wdata,
  output logic [RW-1:0] sz_rdata,
  input  logic          ep_en_set,
  input  logic          ep_dis_req,
  output logic          ep_en,
  input  logic [BW-1:0] max_pkt,
  input  logic          mem_pkt_wr,
  input  logic          mem_pkt_last,
  input  logic [BW-1:0] mem_pkt_len,
  input  logic          fifo_pkt_rd,
  input  logic          dma_mode,
  input  logic          bus_err,
  input  logic [NI-1:0] irq_clr,
  output logic [NI-1:0] irq_flags
);
  localparam logic [PW-1:0] PKT_ONE = PW'(1);

  logic [1:0]    rst_sync;
  logic          arst_n;
  logic          en_q, en_nxt, en_upd;
  logic          ld;
  logic          byte_dec, pkt_dec;
  logic [BW-1:0] byte_amt, byte_q, byte_nxt;
  logic [PW-1:0] pkt_q, pkt_nxt;
  logic          done_evt, dis_evt, err_evt;
  irq_vec_t      irq_set;
  logic          unused_wdata;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign arst_n = rst_sync[1];

  assign unused_wdata = ^sz_wdata;

  always_comb begin
    ld       = sz_wr & ~en_q;
    byte_dec = en_q & mem_pkt_wr;
    pkt_dec  = en_q & fifo_pkt_rd;
    byte_amt = mem_pkt_last ? mem_pkt_len : max_pkt;
  end

  ep0_down_ctr #(.W(BW)) u_byte_ctr (
    .clk      (clk),
    .rst_n    (arst_n),
    .load     (ld),
    .load_val (sz_wdata[BLO +: BW]),
    .dec_en   (byte_dec),
    .dec_amt  (byte_amt),
    .cnt_q    (byte_q),
    .cnt_nxt  (byte_nxt)
  );

  ep0_down_ctr #(.W(PW)) u_pkt_ctr (
    .clk      (clk),
    .rst_n    (arst_n),
    .load     (ld),
    .load_val (sz_wdata[PLO +: PW]),
    .dec_en   (pkt_dec),
    .dec_amt  (PKT_ONE),
    .cnt_q    (pkt_q),
    .cnt_nxt  (pkt_nxt)
  );

  // completion wins over a disable request in the same cycle
  always_comb begin
    done_evt = en_q & (byte_nxt == '0) & (pkt_nxt == '0);
    dis_evt  = en_q & ep_dis_req & ~done_evt;
    err_evt  = en_q & dma_mode & bus_err;
    en_nxt   = en_q ? ~(done_evt | dis_evt) : ep_en_set;
    en_upd   = en_q | ep_en_set;
    irq_set  = '{buserr: err_evt, dis: dis_evt, done: done_evt};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q <= 1'b0;
    end else if (en_upd) begin
      en_q <= en_nxt;
    end
  end

  for (genvar gi = 0; gi < NI; gi++) begin : g_irq
    ep0_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (arst_n),
      .set   (irq_set[gi]),
      .clr   (irq_clr[gi]),
      .q     (irq_flags[gi])
    );
  end

  // counts are hidden while the hardware owns them
  always_comb begin
    sz_rdata = '0;
    if (!en_q) begin
      sz_rdata[BLO +: BW] = byte_q;
      sz_rdata[PLO +: PW] = pkt_q;
    end
  end

  assign ep_en = en_q;
endmodule

// File: rtl/ep0_in_xfer_chk.sv
module ep0_in_xfer_chk #(
  parameter int RW = 32,
  parameter int BW = 7,
  parameter int PW = 2,
  parameter int NI = 3
) (
  input logic          clk,
  input logic          arst_n,
  input logic          ep_en,
  input logic          sz_wr,
  input logic [RW-1:0] sz_rdata,
  input logic [BW-1:0] byte_q,
  input logic [PW-1:0] pkt_q,
  input logic          dma_mode,
  input logic          bus_err,
  input logic [NI-1:0] irq_clr,
  input logic [NI-1:0] irq_flags
);
  // R5
  byte_no_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ep_en |=> (byte_q <= $past(byte_q)));

  // R6
  pkt_no_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ep_en |=> (pkt_q <= $past(pkt_q)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!ep_en && !sz_wr) |=> ($stable(byte_q) && $stable(pkt_q)));

  // R4
  masked_read_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ep_en |-> (sz_rdata == '0));

  // R7
  done_ends_xfer_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(irq_flags[0]) |-> $fell(ep_en));

  // R9
  fault_needs_dma_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(irq_flags[2]) |-> $past(dma_mode && bus_err));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));
endmodule

bind ep0_in_xfer_tracker ep0_in_xfer_chk #(
  .RW(RW), .BW(BW), .PW(PW), .NI(NI)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .ep_en     (ep_en),
  .sz_wr     (sz_wr),
  .sz_rdata  (sz_rdata),
  .byte_q    (byte_q),
  .pkt_q     (pkt_q),
  .dma_mode  (dma_mode),
  .bus_err   (bus_err),
  .irq_clr   (irq_clr),
  .irq_flags (irq_flags)
);

// File: tb/ep0_in_xfer_tracker_test.sv
`timescale 1ns/1ps
module ep0_in_xfer_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sz_wr = 1'b0;
  logic [31:0] sz_wdata = '0;
  logic [31:0] sz_rdata;
  logic        ep_en_set = 1'b0, ep_dis_req = 1'b0, ep_en;
  logic [6:0]  max_pkt = '0;
  logic        mem_pkt_wr = 1'b0, mem_pkt_last = 1'b0;
  logic [6:0]  mem_pkt_len = '0;
  logic        fifo_pkt_rd = 1'b0, dma_mode = 1'b0, bus_err = 1'b0;
  logic [2:0]  irq_clr = '0;
  logic [2:0]  irq_flags;

  int checks = 0;
  int errors = 0;
  bit model_cmp = 1'b0;

  // requirement-level model
  logic [6:0] m_bytes = '0;
  logic [1:0] m_pkts = '0;
  logic       m_en = 1'b0;
  logic [2:0] m_flags = '0;

  always #4 clk = ~clk;

  ep0_in_xfer_tracker uut (
    .clk(clk), .rst_n(rst_n), .sz_wr(sz_wr), .sz_wdata(sz_wdata),
    .sz_rdata(sz_rdata), .ep_en_set(ep_en_set), .ep_dis_req(ep_dis_req),
    .ep_en(ep_en), .max_pkt(max_pkt), .mem_pkt_wr(mem_pkt_wr),
    .mem_pkt_last(mem_pkt_last), .mem_pkt_len(mem_pkt_len),
    .fifo_pkt_rd(fifo_pkt_rd), .dma_mode(dma_mode), .bus_err(bus_err),
    .irq_clr(irq_clr), .irq_flags(irq_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read();
    return m_en ? 32'h0 : ({11'h0, m_pkts, 19'h0} | {25'h0, m_bytes});
  endfunction

  task automatic model_step();
    logic [6:0] bn, dec;
    logic [1:0] pn;
    logic done, dis, err;
    bn = m_bytes;
    pn = m_pkts;
    if (!m_en && sz_wr) begin
      bn = sz_wdata[6:0];
      pn = sz_wdata[20:19];
    end
    if (m_en && mem_pkt_wr) begin
      dec = mem_pkt_last ? mem_pkt_len : max_pkt;
      bn = (bn > dec) ? bn - dec : 7'd0;
    end
    if (m_en && fifo_pkt_rd) pn = (pn != 0) ? pn - 2'd1 : 2'd0;
    done = m_en && bn == 0 && pn == 0;
    dis  = m_en && ep_dis_req && !done;
    err  = m_en && dma_mode && bus_err;
    m_flags = (m_flags & ~irq_clr) | {err, dis, done};
    m_en = m_en ? !(done || dis) : ep_en_set;
    m_bytes = bn;
    m_pkts = pn;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    if (model_cmp) begin
      chk("R2 R5 R6 model read", sz_rdata, exp_read());
      chk("R3 R7 R8 model enable", {31'h0, ep_en}, {31'h0, m_en});
      chk("R9 R10 model flags", {29'h0, irq_flags}, {29'h0, m_flags});
    end
    sz_wr = 0; ep_en_set = 0; ep_dis_req = 0; mem_pkt_wr = 0;
    mem_pkt_last = 0; fifo_pkt_rd = 0; dma_mode = 0; bus_err = 0; irq_clr = '0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset read", sz_rdata, 32'h0);
    chk("R1 reset enable", {31'h0, ep_en}, 32'h0);
    chk("R1 reset flags", {29'h0, irq_flags}, 32'h0);
    model_cmp = 1'b1;

    sz_wr = 1; sz_wdata = 32'hFFFF_FFFF; tick();
    chk("R2 field layout", sz_rdata, 32'h0018_007F);

    sz_wr = 1; sz_wdata = 32'h0010_0064; ep_en_set = 1; tick();
    chk("R3 enable", {31'h0, ep_en}, 32'h1);
    chk("R4 masked read", sz_rdata, 32'h0);
    sz_wr = 1; sz_wdata = 32'hFFFF_FFFF; tick();
    max_pkt = 7'd64; mem_pkt_wr = 1; tick();
    mem_pkt_wr = 1; mem_pkt_last = 1; mem_pkt_len = 7'd36; tick();
    fifo_pkt_rd = 1; tick();
    chk("R7 not early enable", {31'h0, ep_en}, 32'h1);
    chk("R7 not early flags", {29'h0, irq_flags}, 32'h0);
    fifo_pkt_rd = 1; tick();
    chk("R7 done enable", {31'h0, ep_en}, 32'h0);
    chk("R7 done flag", {29'h0, irq_flags}, 32'h1);
    chk("R3 write ignored while enabled", sz_rdata, 32'h0);
    irq_clr = 3'b001; tick();
    chk("R10 clear", {29'h0, irq_flags}, 32'h0);

    sz_wr = 1; sz_wdata = 32'h0008_0020; ep_en_set = 1; tick();
    max_pkt = 7'd32; mem_pkt_wr = 1; fifo_pkt_rd = 1; tick();
    chk("R7 per-packet done", {29'h0, irq_flags, ep_en} >> 1, 32'h1);
    irq_clr = 3'b111; tick();

    sz_wr = 1; sz_wdata = 32'h0018_000A; ep_en_set = 1; tick();
    max_pkt = 7'd64; mem_pkt_wr = 1; tick();
    ep_dis_req = 1; tick();
    chk("R8 disable enable", {31'h0, ep_en}, 32'h0);
    chk("R8 disable flag", {29'h0, irq_flags}, 32'h2);
    chk("R5 saturate", sz_rdata, 32'h0018_0000);
    mem_pkt_wr = 1; fifo_pkt_rd = 1; tick();
    chk("R11 idle events ignored", sz_rdata, 32'h0018_0000);

    irq_clr = 3'b011; ep_en_set = 1; tick();
    bus_err = 1; tick();
    chk("R9 no dma no fault", {29'h0, irq_flags}, 32'h0);
    bus_err = 1; dma_mode = 1; tick();
    chk("R9 dma fault", {29'h0, irq_flags}, 32'h4);
    bus_err = 1; dma_mode = 1; irq_clr = 3'b100; tick();
    chk("R10 set wins", {29'h0, irq_flags}, 32'h4);
    irq_clr = 3'b100; tick();
    fifo_pkt_rd = 1; tick();
    fifo_pkt_rd = 1; tick();
    fifo_pkt_rd = 1; ep_dis_req = 1; tick();
    chk("R8 done beats disable", {29'h0, irq_flags}, 32'h1);
    chk("R6 pkt count to zero", {31'h0, ep_en}, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      sz_wr        = ($urandom % 6) == 0;
      sz_wdata     = $urandom;
      ep_en_set    = ($urandom % 8) == 0;
      ep_dis_req   = ($urandom % 40) == 0;
      max_pkt      = 7'($urandom);
      mem_pkt_wr   = ($urandom % 3) == 0;
      mem_pkt_last = ($urandom % 4) == 0;
      mem_pkt_len  = 7'($urandom);
      fifo_pkt_rd  = ($urandom % 4) == 0;
      dma_mode     = ($urandom % 2) == 0;
      bus_err      = ($urandom % 30) == 0;
      irq_clr      = (($urandom % 5) == 0) ? 3'($urandom) : 3'b000;
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule